// File: doc/BRIEF.md
# Mode-Dependent Port Status LED Driver

This block drives one green status LED for each of a group of optical ports (four by default). Each port is strapped by a control input either as a radio baseband link or as an Ethernet port, and the LED pattern follows a different rule set in each mode. In baseband mode the LED reports the health of the link to the radio unit. It is dark when the port is disabled or unplugged, blinks fast on a radio alarm, blinks slowly while communication is still being set up, and is solid once communication is up. In Ethernet mode it is dark when the port is disabled or the link is down, solid when the link is up and idle, and blinks while traffic passes.

One shared prescaler divides the core clock down to a base tick, 1 ms by default at 125 MHz. Two phase dividers derive a slow blink (1 Hz) and a fast blink (4 Hz) from that tick, both at 50% duty. Single-cycle activity pulses are stretched per port for a hold time counted in ticks (50 ms by default), so one short frame still gives a visible blink. All status inputs are plain level signals taken from external registers. The LED outputs are plain registered levels with no handshake.

Top module: `port_led_status`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every LED output is 0 (off).
- R2: In baseband mode (mode bit = 1), a port that is disabled (enable = 0) or has no cable (cable = 0) shows a dark LED, whatever its alarm, communication and activity inputs are.
- R3: In baseband mode with the port enabled and cabled, an active alarm gives the fast blink pattern. The alarm takes priority over the communication state.
- R4: In baseband mode with the port enabled and cabled, no alarm and communication not established, the LED shows the slow blink pattern.
- R5: In baseband mode with the port enabled, cabled, communicating and with no alarm, the LED is solid on.
- R6: In Ethernet mode (mode bit = 0), a port that is disabled or has its link down shows a dark LED, and activity pulses have no visible effect.
- R7: In Ethernet mode with the port enabled and the link up, the LED is solid on when no activity is being held. The communication and alarm inputs have no effect in this mode.
- R8: An activity pulse on an Ethernet port makes its LED show the fast blink pattern. The hold counter is loaded with HOLD_TICKS on every pulse and counts down once per base tick, so the blink lasts until HOLD_TICKS ticks have passed after the last pulse.
- R9: The base tick occurs once every TICK_DIV clock cycles. The fast phase toggles every FAST_HALF ticks and the slow phase every SLOW_HALF ticks. Both phases start in the on state at reset.
- R10: Ports are independent: the inputs of one port never change the LED of another port.
- R11: Each LED output is registered. It reflects the port inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_mode_i | input | NUM_PORTS | Per-port mode: 1 = radio baseband, 0 = Ethernet |
| port_en_i | input | NUM_PORTS | Per-port administrative enable |
| cable_ok_i | input | NUM_PORTS | Cable present (baseband) or link operationally up (Ethernet) |
| comm_ok_i | input | NUM_PORTS | Communication with the radio unit established (baseband only) |
| alarm_i | input | NUM_PORTS | Radio unit alarm active (baseband only) |
| act_pulse_i | input | NUM_PORTS | Single-cycle traffic activity pulse (Ethernet only) |
| led_o | output | NUM_PORTS | LED drive, 1 = lit |

## Verification
On every cycle, the embedded assertions check the following: the blink phases change only right after a base tick; an activity pulse always starts the hold; the hold ends only on a tick; and dark and solid port states appear on the LED one cycle after their inputs. Only the bench's scenarios can show the rest. These are the exact blink periods and their alignment after reset, alarm priority over a not-yet-communicating link, hold time and retriggering over many ticks, and that mixing modes across ports leaves each LED unaffected by its neighbours.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic {
    PORT_ETH = 1'b0,
    PORT_BB  = 1'b1
  } port_mode_e;

  typedef enum logic [1:0] {
    PAT_DARK  = 2'd0,
    PAT_SOLID = 2'd1,
    PAT_SLOW  = 2'd2,
    PAT_FAST  = 2'd3
  } led_pat_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/led_phase_div.sv
module led_phase_div #(
  parameter int unsigned HALF_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic phase_o
);
  import led_status_pkg::*;

  localparam int unsigned CW = cnt_width(HALF_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = ph_q;

  // R9: a phase edge is always preceded by a base tick
  a_r9_phase_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> $past(tick_i));

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int unsigned TICK_DIV  = 125000,
  parameter int unsigned FAST_HALF = 125,
  parameter int unsigned SLOW_HALF = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic fast_ph_o,
  output logic slow_ph_o
);
  import led_status_pkg::*;

  localparam int unsigned DW = cnt_width(TICK_DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  generate
    if (TICK_DIV <= 1) begin : g_no_div
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DIV_LAST);
    end
  endgenerate

  led_phase_div #(.HALF_TICKS(FAST_HALF)) u_fast (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_o),
    .phase_o (fast_ph_o)
  );

  led_phase_div #(.HALF_TICKS(SLOW_HALF)) u_slow (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_o),
    .phase_o (slow_ph_o)
  );

endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
  parameter int unsigned HOLD_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic act_i,
  output logic busy_o
);
  import led_status_pkg::*;

  localparam int unsigned HW = cnt_width(HOLD_TICKS + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_TICKS);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hold_q <= '0;
    else if (act_i)                      hold_q <= LOAD;
    else if (tick_i && hold_q != '0)     hold_q <= hold_q - 1'b1;
  end

  assign busy_o = (hold_q != '0);

  // R8: every pulse starts (or restarts) the hold
  a_r8_pulse_starts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> busy_o);

  // R8: the hold can only expire on a base tick
  a_r8_hold_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i));

endmodule

// File: rtl/led_pattern_sel.sv
module led_pattern_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic en_i,
  input  logic cable_i,
  input  logic comm_i,
  input  logic alarm_i,
  input  logic busy_i,
  input  logic fast_ph_i,
  input  logic slow_ph_i,
  output logic led_o
);
  import led_status_pkg::*;

  led_pat_e pat;
  logic     led_d;
  logic     led_q;
  logic     present;

  assign present = en_i & cable_i;

  always_comb begin
    pat = PAT_DARK;
    if (port_mode_e'(mode_i) == PORT_BB) begin
      if (!present)      pat = PAT_DARK;
      else if (alarm_i)  pat = PAT_FAST;
      else if (!comm_i)  pat = PAT_SLOW;
      else               pat = PAT_SOLID;
    end else begin
      if (!present)      pat = PAT_DARK;
      else if (busy_i)   pat = PAT_FAST;
      else               pat = PAT_SOLID;
    end
  end

  always_comb begin
    unique case (pat)
      PAT_DARK:  led_d = 1'b0;
      PAT_SOLID: led_d = 1'b1;
      PAT_SLOW:  led_d = slow_ph_i;
      PAT_FAST:  led_d = fast_ph_i;
      default:   led_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  assign led_o = led_q;

  // R2: absent baseband port is dark next cycle
  a_r2_bb_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !(en_i && cable_i)) |=> !led_o);

  // R5: healthy baseband port is lit next cycle
  a_r5_bb_solid: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && en_i && cable_i && comm_i && !alarm_i) |=> led_o);

  // R6: absent Ethernet port is dark next cycle
  a_r6_eth_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !(en_i && cable_i)) |=> !led_o);

  // R7: idle Ethernet link is lit next cycle
  a_r7_eth_solid: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && en_i && cable_i && !busy_i) |=> led_o);

endmodule

// File: rtl/port_led_status.sv
module port_led_status #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned TICK_DIV   = 125000,
  parameter int unsigned FAST_HALF  = 125,
  parameter int unsigned SLOW_HALF  = 500,
  parameter int unsigned HOLD_TICKS = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_mode_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  input  logic [NUM_PORTS-1:0] cable_ok_i,
  input  logic [NUM_PORTS-1:0] comm_ok_i,
  input  logic [NUM_PORTS-1:0] alarm_i,
  input  logic [NUM_PORTS-1:0] act_pulse_i,
  output logic [NUM_PORTS-1:0] led_o
);

  logic tick;
  logic fast_ph;
  logic slow_ph;

  led_blink_gen #(
    .TICK_DIV  (TICK_DIV),
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF)
  ) u_blink (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_o    (tick),
    .fast_ph_o (fast_ph),
    .slow_ph_o (slow_ph)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic busy;

    led_act_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .act_i  (act_pulse_i[p]),
      .busy_o (busy)
    );

    led_pattern_sel u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (port_mode_i[p]),
      .en_i      (port_en_i[p]),
      .cable_i   (cable_ok_i[p]),
      .comm_i    (comm_ok_i[p]),
      .alarm_i   (alarm_i[p]),
      .busy_i    (busy),
      .fast_ph_i (fast_ph),
      .slow_ph_i (slow_ph),
      .led_o     (led_o[p])
    );
  end

  // R1: outputs dark in the first cycle out of reset
  a_r1_dark_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (led_o == '0));

endmodule

// File: tb/port_led_status_bench.sv
module port_led_status_bench;

  localparam int NP    = 4;
  localparam int TDIV  = 4;
  localparam int FHALF = 2;
  localparam int SHALF = 6;
  localparam int HOLD  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] mode = '0, en = '0, cab = '0, comm = '0, alm = '0, act = '0;
  logic [NP-1:0] led;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  port_led_status #(
    .NUM_PORTS(NP), .TICK_DIV(TDIV), .FAST_HALF(FHALF),
    .SLOW_HALF(SHALF), .HOLD_TICKS(HOLD)
  ) u_port_led_status (
    .clk(clk), .rst_n(rst_n), .port_mode_i(mode), .port_en_i(en),
    .cable_ok_i(cab), .comm_ok_i(comm), .alarm_i(alm),
    .act_pulse_i(act), .led_o(led)
  );

  // behavioural reference model
  int  m_div, m_fc, m_sc, m_hold[NP];
  bit  m_fph, m_sph;
  bit  exp_led[NP];
  string exp_tag[NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_fc = 0; m_sc = 0; m_fph = 1; m_sph = 1;
      for (int i = 0; i < NP; i++) begin
        m_hold[i] = 0; exp_led[i] = 0; exp_tag[i] = "R1";
      end
    end else begin
      bit tk;
      cyc++;
      tk = (m_div == TDIV - 1);
      for (int i = 0; i < NP; i++) begin
        if (mode[i]) begin
          if (!(en[i] && cab[i]))  begin exp_led[i] = 0;     exp_tag[i] = "R2"; end
          else if (alm[i])         begin exp_led[i] = m_fph; exp_tag[i] = "R3"; end
          else if (!comm[i])       begin exp_led[i] = m_sph; exp_tag[i] = "R4"; end
          else                     begin exp_led[i] = 1;     exp_tag[i] = "R5"; end
        end else begin
          if (!(en[i] && cab[i]))  begin exp_led[i] = 0;     exp_tag[i] = "R6"; end
          else if (m_hold[i] > 0)  begin exp_led[i] = m_fph; exp_tag[i] = "R8"; end
          else                     begin exp_led[i] = 1;     exp_tag[i] = "R7"; end
        end
        if (act[i])                  m_hold[i] = HOLD;
        else if (tk && m_hold[i] > 0) m_hold[i]--;
      end
      if (tk) begin
        m_div = 0;
        if (m_fc == FHALF - 1) begin m_fc = 0; m_fph = !m_fph; end else m_fc++;
        if (m_sc == SHALF - 1) begin m_sc = 0; m_sph = !m_sph; end else m_sc++;
      end else m_div++;
    end
  end

  task automatic check(input string tag, input logic act_v, input logic exp_v);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act_v, exp_v);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rst_n)
      for (int i = 0; i < NP; i++) check(exp_tag[i], led[i], exp_led[i]);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [NP-1:0] m);
    act = m; @(negedge clk); act = '0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int toggles;
    logic prev;
    // R1: dark during reset
    run(3);
    check("R1", led[0] | led[1] | led[2] | led[3], 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", led[0] | led[1] | led[2] | led[3], 1'b0);

    // R2 baseband dark with noisy inputs, R6 Ethernet dark with activity
    mode = 4'b0011; en = 4'b0101; cab = 4'b1010; alm = 4'b1111; comm = 4'b1111;
    run(10); pulse(4'b1100); run(30);

    // R4 slow, R3 fast (alarm over no-comm), R5 solid, R9 phases via model
    mode = 4'b1111; en = 4'b1111; cab = 4'b1111;
    comm = 4'b0101; alm = 4'b0011;
    run(120);

    // R11: port 3 goes dark->solid; lit exactly one edge later
    mode = 4'b1111; comm = 4'b1000; alm = 4'b0000; cab = 4'b0111;
    run(2);
    cab = 4'b1111;
    @(negedge clk);
    check("R11", led[3], 1'b1);

    // R7 Ethernet solid, comm/alarm ignored
    mode = 4'b0000; comm = 4'b1010; alm = 4'b0110;
    run(20);

    // R8 single pulse, then retrigger before hold expiry
    pulse(4'b0001); run(40);
    pulse(4'b0010); run(10); pulse(4'b0010); run(10); pulse(4'b0010); run(40);

    // R10 mixed modes: port0 solid while port1 blinks on alarm
    mode = 4'b0110; comm = 4'b0110; alm = 4'b0010; en = 4'b1111; cab = 4'b1111;
    run(2);
    toggles = 0; prev = led[1];
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("R10", led[0], 1'b1);
      if (led[1] !== prev) toggles++;
      prev = led[1];
    end
    check("R10", (toggles > 0), 1'b1);
    run(20);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule